// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block turns a 10-bit CPU address into a 16-bit physical address for a 64 KiB memory, with ROM in the lower half and RAM in the upper half. The CPU address space is split by its top bit into two 512-byte windows. The lower window can show any of the 128 physical banks of 512 bytes. The upper window always shows the last bank, which holds the stack and the I/O ports. A 7-bit bank register, written by the CPU at a fixed address in the upper window, selects the bank seen through the lower window.

Each access falls into one of four targets: NONE (no read or write strobe), IO (the address lies in the eight-byte I/O window 0x3B8 to 0x3BF), ROM (the resolved bank number is below 64) or RAM (the resolved bank number is 64 or above). The target sets exactly one of the select outputs. A write strobe reaches memory only when the target is RAM, so writes into ROM banks are dropped. The bank register is the only stored state. Its next value is the write data when the CPU writes to 0x3B8, and otherwise it keeps its value. Translation itself is combinational and uses the value the register holds at that moment.

Top module: `bank_mapper`

## Requirements
- R1: After reset the bank register holds 0, a read at 0x3B8 returns 0, and lower-window addresses map to physical address equal to the CPU address with ROM selected.
- R2: For CPU addresses with bit 9 clear, phys_addr is the 7-bit bank register value in bits 15:9 and CPU address bits 8:0 in bits 8:0.
- R3: For CPU addresses with bit 9 set, phys_addr bits 15:9 are 0x7F whatever the bank register holds, and bits 8:0 are CPU address bits 8:0.
- R4: During an access outside the I/O window, rom_cs is high when the resolved bank has bit 6 clear (banks 0 to 63), ram_cs is high when bit 6 is set (banks 64 to 127), and never both.
- R5: An access to 0x3B8 to 0x3BF raises io_sel and leaves rom_cs, ram_cs and mem_we low.
- R6: A write to 0x3B8 loads cpu_wdata bits 6:0 into the bank register at that clock edge (bit 7 is ignored). The new bank applies from the next access onward.
- R7: A read at 0x3B8 drives io_rdata with the bank value in bits 6:0 and 0 in bit 7. Any other access, or no access, drives io_rdata to 0.
- R8: mem_we is high only for a write whose target is RAM. Writes that resolve to a ROM bank keep it low.
- R9: With cpu_rd and cpu_wr both low, rom_cs, ram_cs, io_sel and mem_we are all low.
- R10: Writes to any address other than 0x3B8, including the other I/O window addresses, leave the bank register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 10 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| phys_addr | output | 16 | Translated physical address |
| rom_cs | output | 1 | ROM chip select |
| ram_cs | output | 1 | RAM chip select |
| mem_we | output | 1 | Write enable to memory, RAM only |
| io_sel | output | 1 | Access falls in the I/O window |
| io_rdata | output | 8 | Bank register read-back data |

## Verification
The bench builds the block with its default parameters: a 10-bit CPU address, 8-bit data, a 7-bit bank number and an eight-byte I/O window at 0x3B8. With these values all 128 banks can be reached by writing the register. This covers the ROM/RAM boundary between banks 63 and 64, and bank 127 mapped into the lower window as well as the upper one. It also covers the upper data bit that the register discards, and the I/O addresses next to the bank register that must not load it.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    // Resolved destination of one CPU access
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_RAM  = 2'd2,
        TGT_IO   = 2'd3
    } target_e;

endpackage

// File: rtl/bm_bank_reg.sv
module bm_bank_reg #(
    parameter int unsigned CPU_AW  = 10,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned BANK_W  = 7,
    parameter int unsigned REG_ADR = 'h3B8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [BANK_W-1:0] bank_q,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [CPU_AW-1:0] REG_A = CPU_AW'(REG_ADR);

    logic              reg_hit;
    logic              wr_hit;
    logic [BANK_W-1:0] bank_d;
    logic              unused_wdata_hi;

    assign reg_hit         = (cpu_addr == REG_A);
    assign wr_hit          = cpu_wr && reg_hit;
    assign unused_wdata_hi = ^cpu_wdata[DATA_W-1:BANK_W];

    always_comb begin
        bank_d = bank_q;
        if (wr_hit) begin
            bank_d = cpu_wdata[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (cpu_rd && reg_hit) begin
            rdata[BANK_W-1:0] = bank_q;
        end
    end

    // R6: a register write lands at the next edge
    p_bank_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (bank_q == $past(cpu_wdata[BANK_W-1:0])));

    // R10: without a register write the bank is held
    p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(bank_q));

endmodule

// File: rtl/bm_xlate.sv
module bm_xlate #(
    parameter int unsigned CPU_AW = 10,
    parameter int unsigned BANK_W = 7,
    localparam int unsigned OFF_W  = CPU_AW - 1,
    localparam int unsigned PHYS_W = BANK_W + OFF_W
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [BANK_W-1:0] bank_q,
    output logic [BANK_W-1:0] phys_bank,
    output logic [PHYS_W-1:0] phys_addr
);

    logic common_blk;

    assign common_blk = cpu_addr[CPU_AW-1];

    always_comb begin
        if (common_blk) begin
            phys_bank = '1;
        end else begin
            phys_bank = bank_q;
        end
        phys_addr = {phys_bank, cpu_addr[OFF_W-1:0]};
    end

endmodule

// File: rtl/bm_decode.sv
module bm_decode
    import bankmap_pkg::*;
#(
    parameter int unsigned CPU_AW  = 10,
    parameter int unsigned BANK_W  = 7,
    parameter int unsigned IO_BASE = 'h3B8,
    parameter int unsigned IO_AW   = 3
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [BANK_W-1:0] phys_bank,
    output logic              rom_cs,
    output logic              ram_cs,
    output logic              io_sel,
    output logic              mem_we
);

    localparam logic [CPU_AW-1:0] IO_A = CPU_AW'(IO_BASE);

    logic    io_hit;
    logic    unused_lo;
    target_e tgt;

    assign io_hit    = (cpu_addr[CPU_AW-1:IO_AW] == IO_A[CPU_AW-1:IO_AW]);
    assign unused_lo = ^{cpu_addr[IO_AW-1:0], phys_bank[BANK_W-2:0]};

    always_comb begin
        if (!(cpu_rd || cpu_wr)) begin
            tgt = TGT_NONE;
        end else if (io_hit) begin
            tgt = TGT_IO;
        end else if (phys_bank[BANK_W-1]) begin
            tgt = TGT_RAM;
        end else begin
            tgt = TGT_ROM;
        end
    end

    always_comb begin
        rom_cs = 1'b0;
        ram_cs = 1'b0;
        io_sel = 1'b0;
        mem_we = 1'b0;
        unique case (tgt)
            TGT_NONE: ;
            TGT_ROM:  rom_cs = 1'b1;
            TGT_RAM: begin
                ram_cs = 1'b1;
                mem_we = cpu_wr;
            end
            TGT_IO:   io_sel = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper #(
    parameter int unsigned CPU_AW  = 10,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned BANK_W  = 7,
    parameter int unsigned IO_BASE = 'h3B8,
    parameter int unsigned IO_AW   = 3,
    localparam int unsigned OFF_W  = CPU_AW - 1,
    localparam int unsigned PHYS_W = BANK_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              rom_cs,
    output logic              ram_cs,
    output logic              mem_we,
    output logic              io_sel,
    output logic [DATA_W-1:0] io_rdata
);

    logic [BANK_W-1:0] bank_q;
    logic [BANK_W-1:0] phys_bank;

    bm_bank_reg #(
        .CPU_AW (CPU_AW),
        .DATA_W (DATA_W),
        .BANK_W (BANK_W),
        .REG_ADR(IO_BASE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .cpu_wdata(cpu_wdata),
        .bank_q   (bank_q),
        .rdata    (io_rdata)
    );

    bm_xlate #(
        .CPU_AW(CPU_AW),
        .BANK_W(BANK_W)
    ) u_xlate (
        .cpu_addr (cpu_addr),
        .bank_q   (bank_q),
        .phys_bank(phys_bank),
        .phys_addr(phys_addr)
    );

    bm_decode #(
        .CPU_AW (CPU_AW),
        .BANK_W (BANK_W),
        .IO_BASE(IO_BASE),
        .IO_AW  (IO_AW)
    ) u_dec (
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .phys_bank(phys_bank),
        .rom_cs   (rom_cs),
        .ram_cs   (ram_cs),
        .io_sel   (io_sel),
        .mem_we   (mem_we)
    );

    // R4: at most one destination selected
    p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs, ram_cs, io_sel}));

    // R3: upper window is pinned to the last bank
    p_common_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[CPU_AW-1] |-> (phys_addr[PHYS_W-1:OFF_W] == '1));

    // R8: ROM never sees a write strobe
    p_rom_no_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> !mem_we);

    // R5: I/O window excludes memory selects
    p_io_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> (!ram_cs && !rom_cs && !mem_we));

    // R9: idle bus drives nothing
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> !(rom_cs || ram_cs || io_sel || mem_we));

endmodule

// File: tb/bank_mapper_tb_top.sv
module bank_mapper_tb_top;

    localparam int unsigned REG_ADR = 'h3B8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [15:0] phys_addr;
    logic        rom_cs, ram_cs, mem_we, io_sel;
    logic [7:0]  io_rdata;

    int checks = 0;
    int failures = 0;
    logic [6:0] model_bank = '0;

    always #2 clk = ~clk;

    bank_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .phys_addr(phys_addr),
        .rom_cs(rom_cs), .ram_cs(ram_cs), .mem_we(mem_we), .io_sel(io_sel),
        .io_rdata(io_rdata)
    );

    function automatic logic [15:0] f_phys(input logic [9:0] a, input logic [6:0] b);
        return {(a[9] ? 7'h7F : b), a[8:0]};
    endfunction

    function automatic logic f_io(input logic [9:0] a);
        return (a >= 10'h3B8) && (a <= 10'h3BF);
    endfunction

    task automatic cmp(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        logic acc, eio, eram, erom, ewe;
        logic [6:0] eb;
        logic [7:0] erd;
        string ctag;
        acc  = cpu_rd || cpu_wr;
        eb   = cpu_addr[9] ? 7'h7F : model_bank;
        eio  = acc && f_io(cpu_addr);
        eram = acc && !eio && eb[6];
        erom = acc && !eio && !eb[6];
        ewe  = cpu_wr && eram;
        erd  = (cpu_rd && cpu_addr == 10'(REG_ADR)) ? {1'b0, model_bank} : 8'h00;
        ctag = !acc ? "R9" : (eio ? "R5" : "R4");
        cmp(cpu_addr[9] ? "R3" : "R2", "phys_addr", phys_addr, f_phys(cpu_addr, model_bank));
        cmp(ctag, "rom_cs", 16'(rom_cs), 16'(erom));
        cmp(ctag, "ram_cs", 16'(ram_cs), 16'(eram));
        cmp("R5", "io_sel", 16'(io_sel), 16'(eio));
        cmp("R8", "mem_we", 16'(mem_we), 16'(ewe));
        cmp("R7", "io_rdata", 16'(io_rdata), 16'(erd));
    endtask

    task automatic access(input logic [9:0] a, input logic rd, input logic wr,
                          input logic [7:0] wd);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
        #1;
        check_all();
        @(posedge clk);
        if (wr && a == 10'(REG_ADR)) model_bank = wd[6:0];
    endtask

    // read back the bank register against a value fixed by the requirement
    task automatic expect_bank(input logic [6:0] exp, input string tag);
        @(negedge clk);
        cpu_addr = 10'(REG_ADR); cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        cmp(tag, "bank readback", 16'(io_rdata), 16'({1'b0, exp}));
        @(posedge clk);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd5151));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_bank(7'h00, "R1");
        @(negedge clk);
        cpu_addr = 10'h123; cpu_rd = 1'b1; cpu_wr = 1'b0; #1;
        cmp("R1", "phys after reset", phys_addr, 16'h0123);
        cmp("R1", "rom_cs after reset", 16'(rom_cs), 16'd1);
        @(posedge clk);

        // R9: idle
        access(10'h010, 1'b0, 1'b0, 8'h00);
        // R8: write into ROM bank 0 blocked
        access(10'h044, 1'b0, 1'b1, 8'hAA);

        // R6: load bank 64, takes effect next access
        access(10'(REG_ADR), 1'b0, 1'b1, 8'h40);
        expect_bank(7'h40, "R6");
        access(10'h005, 1'b0, 1'b1, 8'h11);   // RAM write, R8
        // ROM/RAM boundary: bank 63
        access(10'(REG_ADR), 1'b0, 1'b1, 8'h3F);
        access(10'h1FF, 1'b0, 1'b1, 8'h22);
        access(10'h1FF, 1'b1, 1'b0, 8'h00);
        // bank 127 in lower window
        access(10'(REG_ADR), 1'b0, 1'b1, 8'h7F);
        access(10'h000, 1'b1, 1'b0, 8'h00);
        // R6: data bit 7 ignored
        access(10'(REG_ADR), 1'b0, 1'b1, 8'h85);
        expect_bank(7'h05, "R6");
        // R3: upper window ignores bank
        access(10'h200, 1'b1, 1'b0, 8'h00);
        access(10'h3FF, 1'b0, 1'b1, 8'h33);
        // R10: other I/O addresses leave the bank alone
        access(10'h3B9, 1'b0, 1'b1, 8'h66);
        access(10'h3BF, 1'b0, 1'b1, 8'h77);
        access(10'h3B7, 1'b0, 1'b1, 8'h12);
        expect_bank(7'h05, "R10");
        // R5: reads in the window
        access(10'h3BC, 1'b1, 1'b0, 8'h00);

        for (int i = 0; i < 3000; i++) begin
            logic [9:0] a;
            logic [1:0] op;
            a  = 10'($urandom);
            op = 2'($urandom);
            if (($urandom % 8) == 0) a = 10'(REG_ADR);
            access(a, op[0], op[1], 8'($urandom));
        end
        expect_bank(model_bank, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule